// File: doc/BRIEF.md
# Wishbone Diagnostic Register Bank

This block is a Wishbone classic slave that holds a small bank of 32-bit, word-addressed registers. An identification word and a version word sit at the two lowest addresses. A parameter can enable a group of four diagnostic registers placed directly after them. The user control registers follow, and the user status registers come after those. The control registers drive output ports, and the status registers are sampled from input ports.

The diagnostic group lets a bus master test its own error and timeout handling.

- One register is an ordinary read/write scratch word.
- A write-only register and a read-only register form a loopback pair.
- A read of the write-only register ends in a bus error.
- One register never responds at all, so the master's timeout path can be exercised.

Each control register can have a one-clock write strobe, and each status register can have a one-clock read pulse. User logic can use these to act on a bus access. A read of an address that holds no register returns a fixed filler pattern with a normal acknowledge.

Every accepted cycle is answered in the clock after `cyc` and `stb` are seen. The answer is registered, so no combinational path runs from the bus inputs to the response.

Top module: `wb_diag_regbank`

## Requirements
- R1: Address 0 reads the ID_WORD parameter and address 1 reads the VER_WORD parameter. Both acknowledge writes, and a write leaves their value unchanged.
- R2: Every accepted cycle except one addressed to the timeout register raises exactly one of `wb_ack_o` or `wb_err_o`. That response is high for a single clock, in the cycle after `wb_cyc_i` and `wb_stb_i` were sampled high. On an acknowledged read, `wb_dat_o` carries the read word in that same cycle.
- R3: With DIAG_EN=1, address 2 is a scratch register. It resets to 0 and reads back the last value written to it.
- R4: With DIAG_EN=1, a write to address 3 is acknowledged and stores the written word. A read of address 3 raises `wb_err_o` and no acknowledge.
- R5: With DIAG_EN=1, a read of address 4 returns the last word stored at address 3, or 0 after reset. A write to address 4 is acknowledged and has no effect.
- R6: With DIAG_EN=1, a read or a write of address 5 is never answered: `wb_ack_o` and `wb_err_o` stay low for as long as the master holds the cycle.
- R7: The user registers start at address 2 when DIAG_EN=0 and at address 6 when DIAG_EN=1. Control register i sits at that base plus i. Status register j sits at that base plus N_CTRL plus j. With DIAG_EN=0, addresses 2 to 5 are user registers or unmapped addresses and carry no diagnostic behaviour.
- R8: Control register i drives `ctrl_o[32*i +: 32]`. It resets to `CTRL_RST[32*i +: 32]` and reads back the last value written. Its output changes in the same cycle as the acknowledge of the write.
- R9: When bit i of CTRL_STB_EN is 1, `ctrl_wr_o[i]` is high for exactly the acknowledge cycle of each write to control register i. When the bit is 0, `ctrl_wr_o[i]` stays low. Reads never raise the strobe.
- R10: A read of status register j returns `stat_i[32*j +: 32]` as sampled at the clock edge that accepts the cycle. A write to it is acknowledged and ignored.
- R11: When bit j of STAT_ACK_EN is 1, `stat_rd_o[j]` is high for exactly the acknowledge cycle of each read of status register j. When the bit is 0, `stat_rd_o[j]` stays low. Writes never raise the pulse.
- R12: A read of an address that holds no register returns 32'hA5A5A5A5 with `wb_ack_o` high and `wb_err_o` low. A write to such an address is acknowledged and changes nothing.
- R13: `rst_n` low clears `wb_ack_o` and `wb_err_o` and loads every control register with its default. This happens asynchronously, and the reset is released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Normal termination |
| wb_err_o | output | 1 | Error termination |
| ctrl_o | output | 32*N_CTRL | Control register contents, register i in bits 32*i+31..32*i |
| ctrl_wr_o | output | N_CTRL | One-clock write strobe per control register |
| stat_i | input | 32*N_STAT | Status words, register j in bits 32*j+31..32*j |
| stat_rd_o | output | N_STAT | One-clock read pulse per status register |

## Verification
The bench builds two instances side by side.

The first has DIAG_EN=1, three control registers and two status registers. Its strobe and pulse masks are mixed (101 and 10), so both the enabled and the disabled branch of each generate choice are covered. This instance reaches the error, timeout and loopback paths, and it takes a long random mix of reads and writes checked against a model of the bank.

The second has DIAG_EN=0, two control registers and one status register. It shows the user base moving down to address 2, and it shows that address 5 then acknowledges as an unmapped address instead of hanging the bus.

// File: rtl/wbrb_pkg.sv
package wbrb_pkg;

  localparam int WORD_W      = 32;
  localparam int FIXED_SLOTS = 2;   // identification + version
  localparam int DIAG_SLOTS  = 4;   // scratch, write-only, read-only, no-response

  localparam logic [WORD_W-1:0] FILLER_WORD = 32'hA5A5_A5A5;

  typedef enum logic [3:0] {
    RK_ID,
    RK_VER,
    RK_SCRATCH,
    RK_WONLY,
    RK_RONLY,
    RK_HANG,
    RK_CTRL,
    RK_STAT,
    RK_NONE
  } reg_kind_e;

endpackage

// File: rtl/wbrb_rst_sync.sv
module wbrb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/wbrb_decode.sv
module wbrb_decode
  import wbrb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIAG_EN = 1,
  parameter int N_CTRL  = 2,
  parameter int N_STAT  = 2
) (
  input  logic [ADDR_W-1:0] adr,
  output reg_kind_e         kind,
  output logic [N_CTRL-1:0] ctrl_sel,
  output logic [N_STAT-1:0] stat_sel
);

  localparam int USER_BASE = FIXED_SLOTS + ((DIAG_EN != 0) ? DIAG_SLOTS : 0);
  localparam int STAT_BASE = USER_BASE + N_CTRL;

  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(FIXED_SLOTS);
  localparam logic [ADDR_W-1:0] A_WO   = ADDR_W'(FIXED_SLOTS + 1);
  localparam logic [ADDR_W-1:0] A_RO   = ADDR_W'(FIXED_SLOTS + 2);
  localparam logic [ADDR_W-1:0] A_HANG = ADDR_W'(FIXED_SLOTS + 3);

  for (genvar gi = 0; gi < N_CTRL; gi++) begin : g_csel
    assign ctrl_sel[gi] = (adr == ADDR_W'(USER_BASE + gi));
  end

  for (genvar gj = 0; gj < N_STAT; gj++) begin : g_ssel
    assign stat_sel[gj] = (adr == ADDR_W'(STAT_BASE + gj));
  end

  always_comb begin
    kind = RK_NONE;
    if (adr == A_ID) begin
      kind = RK_ID;
    end else if (adr == A_VER) begin
      kind = RK_VER;
    end else if (|ctrl_sel) begin
      kind = RK_CTRL;
    end else if (|stat_sel) begin
      kind = RK_STAT;
    end else if (DIAG_EN != 0) begin
      if (adr == A_SCR)       kind = RK_SCRATCH;
      else if (adr == A_WO)   kind = RK_WONLY;
      else if (adr == A_RO)   kind = RK_RONLY;
      else if (adr == A_HANG) kind = RK_HANG;
    end
  end

endmodule

// File: rtl/wbrb_diag.sv
module wbrb_diag
  import wbrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] scratch_q,
  output logic [WORD_W-1:0] loop_q
);

  logic scratch_ld;
  logic loop_ld;

  always_comb begin
    scratch_ld = wr_en & (kind == RK_SCRATCH);
    loop_ld    = wr_en & (kind == RK_WONLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (scratch_ld) begin
      scratch_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
    end else if (loop_ld) begin
      loop_q <= wr_data;
    end
  end

endmodule

// File: rtl/wbrb_ctrl_bank.sv
module wbrb_ctrl_bank
  import wbrb_pkg::*;
#(
  parameter int                       N_CTRL      = 2,
  parameter logic [N_CTRL*WORD_W-1:0] CTRL_RST    = '0,
  parameter logic [N_CTRL-1:0]        CTRL_STB_EN = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [N_CTRL-1:0]          sel,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [WORD_W-1:0]          rd_word,
  output logic [N_CTRL*WORD_W-1:0]   ctrl_q,
  output logic [N_CTRL-1:0]          wr_pulse
);

  logic [N_CTRL-1:0] load;

  for (genvar gi = 0; gi < N_CTRL; gi++) begin : g_reg
    logic [WORD_W-1:0] val_q;

    assign load[gi] = wr_en & sel[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= CTRL_RST[gi*WORD_W +: WORD_W];
      end else if (load[gi]) begin
        val_q <= wr_data;
      end
    end

    assign ctrl_q[gi*WORD_W +: WORD_W] = val_q;

    if (CTRL_STB_EN[gi]) begin : g_stb
      logic stb_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stb_q <= 1'b0;
        end else begin
          stb_q <= load[gi];
        end
      end
      assign wr_pulse[gi] = stb_q;
    end else begin : g_nostb
      assign wr_pulse[gi] = 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_CTRL; i++) begin
      rd_word = rd_word | (ctrl_q[i*WORD_W +: WORD_W] & {WORD_W{sel[i]}});
    end
  end

endmodule

// File: rtl/wbrb_stat_bank.sv
module wbrb_stat_bank
  import wbrb_pkg::*;
#(
  parameter int                N_STAT      = 2,
  parameter logic [N_STAT-1:0] STAT_ACK_EN = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [N_STAT-1:0]        sel,
  input  logic [N_STAT*WORD_W-1:0] stat_in,
  output logic [WORD_W-1:0]        rd_word,
  output logic [N_STAT-1:0]        rd_pulse
);

  for (genvar gj = 0; gj < N_STAT; gj++) begin : g_ack
    if (STAT_ACK_EN[gj]) begin : g_on
      logic pls_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pls_q <= 1'b0;
        end else begin
          pls_q <= rd_en & sel[gj];
        end
      end
      assign rd_pulse[gj] = pls_q;
    end else begin : g_off
      assign rd_pulse[gj] = 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < N_STAT; j++) begin
      rd_word = rd_word | (stat_in[j*WORD_W +: WORD_W] & {WORD_W{sel[j]}});
    end
  end

endmodule

// File: rtl/wb_diag_regbank.sv
module wb_diag_regbank
  import wbrb_pkg::*;
#(
  parameter int                       ADDR_W      = 8,
  parameter logic [31:0]              ID_WORD     = 32'h5EB0_0001,
  parameter logic [31:0]              VER_WORD    = 32'h0001_0000,
  parameter int                       DIAG_EN     = 1,
  parameter int                       N_CTRL      = 2,
  parameter int                       N_STAT      = 2,
  parameter logic [N_CTRL*32-1:0]     CTRL_RST    = {32'h0000_00FF, 32'h1234_0000},
  parameter logic [N_CTRL-1:0]        CTRL_STB_EN = '1,
  parameter logic [N_STAT-1:0]        STAT_ACK_EN = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wb_cyc_i,
  input  logic                   wb_stb_i,
  input  logic                   wb_we_i,
  input  logic [ADDR_W-1:0]      wb_adr_i,
  input  logic [31:0]            wb_dat_i,
  output logic [31:0]            wb_dat_o,
  output logic                   wb_ack_o,
  output logic                   wb_err_o,
  output logic [N_CTRL*32-1:0]   ctrl_o,
  output logic [N_CTRL-1:0]      ctrl_wr_o,
  input  logic [N_STAT*32-1:0]   stat_i,
  output logic [N_STAT-1:0]      stat_rd_o
);

  logic              rst_core_n;
  reg_kind_e         kind;
  logic [N_CTRL-1:0] ctrl_sel;
  logic [N_STAT-1:0] stat_sel;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] scratch_val;
  logic [WORD_W-1:0] loop_val;

  logic              accept;
  logic              respond;
  logic              wr_en;
  logic              rd_en;
  logic              ack_d, ack_q;
  logic              err_d, err_q;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] dat_d, dat_q;

  wbrb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  wbrb_decode #(
    .ADDR_W  (ADDR_W),
    .DIAG_EN (DIAG_EN),
    .N_CTRL  (N_CTRL),
    .N_STAT  (N_STAT)
  ) i_decode (
    .adr      (wb_adr_i),
    .kind     (kind),
    .ctrl_sel (ctrl_sel),
    .stat_sel (stat_sel)
  );

  wbrb_ctrl_bank #(
    .N_CTRL      (N_CTRL),
    .CTRL_RST    (CTRL_RST),
    .CTRL_STB_EN (CTRL_STB_EN)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .sel      (ctrl_sel),
    .wr_data  (wb_dat_i),
    .rd_word  (ctrl_word),
    .ctrl_q   (ctrl_o),
    .wr_pulse (ctrl_wr_o)
  );

  wbrb_stat_bank #(
    .N_STAT      (N_STAT),
    .STAT_ACK_EN (STAT_ACK_EN)
  ) i_stat (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_en    (rd_en),
    .sel      (stat_sel),
    .stat_in  (stat_i),
    .rd_word  (stat_word),
    .rd_pulse (stat_rd_o)
  );

  if (DIAG_EN != 0) begin : g_diag
    wbrb_diag i_diag (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_en     (wr_en),
      .kind      (kind),
      .wr_data   (wb_dat_i),
      .scratch_q (scratch_val),
      .loop_q    (loop_val)
    );
  end else begin : g_nodiag
    assign scratch_val = '0;
    assign loop_val    = '0;
  end

  // Next-state logic for the registered bus response.
  always_comb begin
    accept  = wb_cyc_i & wb_stb_i & ~ack_q & ~err_q;
    respond = accept & (kind != RK_HANG);
    wr_en   = accept & wb_we_i;
    rd_en   = accept & ~wb_we_i;
    err_d   = respond & ~wb_we_i & (kind == RK_WONLY);
    ack_d   = respond & ~err_d;

    unique case (kind)
      RK_ID:      rd_word = ID_WORD;
      RK_VER:     rd_word = VER_WORD;
      RK_SCRATCH: rd_word = scratch_val;
      RK_RONLY:   rd_word = loop_val;
      RK_CTRL:    rd_word = ctrl_word;
      RK_STAT:    rd_word = stat_word;
      RK_NONE:    rd_word = FILLER_WORD;
      default:    rd_word = '0;
    endcase

    dat_d = (ack_d & ~wb_we_i) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
      dat_q <= dat_d;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_err_o = err_q;
  assign wb_dat_o = dat_q;

endmodule

// File: rtl/wbrb_chk.sv
module wbrb_chk #(
  parameter int ADDR_W  = 8,
  parameter int DIAG_EN = 1,
  parameter int N_CTRL  = 2,
  parameter int N_STAT  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wb_cyc_i,
  input logic                 wb_stb_i,
  input logic                 wb_we_i,
  input logic [ADDR_W-1:0]    wb_adr_i,
  input logic [31:0]          wb_dat_o,
  input logic                 wb_ack_o,
  input logic                 wb_err_o,
  input logic [N_CTRL*32-1:0] ctrl_o,
  input logic [N_CTRL-1:0]    ctrl_wr_o,
  input logic [N_STAT-1:0]    stat_rd_o
);

  localparam int USER_BASE = 2 + ((DIAG_EN != 0) ? 4 : 0);
  localparam logic [ADDR_W-1:0] A_WO   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HANG = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(USER_BASE + N_CTRL + N_STAT);
  localparam bit HAS_DIAG = (DIAG_EN != 0);

  // R2
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_ack_o && wb_err_o));

  // R2
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_o || wb_err_o) |=> !(wb_ack_o || wb_err_o));

  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_o || wb_err_o) |-> $past(wb_cyc_i && wb_stb_i));

  // R4
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_err_o |-> HAS_DIAG && $past(!wb_we_i && wb_adr_i == A_WO));

  // R6
  hang_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_DIAG && wb_cyc_i && wb_stb_i && wb_adr_i == A_HANG && !wb_ack_o && !wb_err_o)
      |=> !wb_ack_o && !wb_err_o);

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wb_cyc_i && wb_stb_i && wb_we_i) |-> $stable(ctrl_o));

  // R9
  ctrl_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_o != '0) |-> wb_ack_o && $onehot0(ctrl_wr_o) && $past(wb_we_i));

  // R11
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_o != '0) |-> wb_ack_o && $onehot0(stat_rd_o) && $past(!wb_we_i));

  // R12
  filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_o && $past(!wb_we_i && wb_adr_i >= A_END)) |-> wb_dat_o == 32'hA5A5_A5A5);

endmodule

bind wb_diag_regbank wbrb_chk #(
  .ADDR_W  (ADDR_W),
  .DIAG_EN (DIAG_EN),
  .N_CTRL  (N_CTRL),
  .N_STAT  (N_STAT)
) i_wbrb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wb_cyc_i  (wb_cyc_i),
  .wb_stb_i  (wb_stb_i),
  .wb_we_i   (wb_we_i),
  .wb_adr_i  (wb_adr_i),
  .wb_dat_o  (wb_dat_o),
  .wb_ack_o  (wb_ack_o),
  .wb_err_o  (wb_err_o),
  .ctrl_o    (ctrl_o),
  .ctrl_wr_o (ctrl_wr_o),
  .stat_rd_o (stat_rd_o)
);

// File: tb/test_wb_diag_regbank.sv
module test_wb_diag_regbank;

  localparam logic [31:0] A_ID  = 32'hC0DE_0042;
  localparam logic [31:0] A_VER = 32'h0001_0203;
  localparam logic [95:0] A_RST = {32'h0000_0033, 32'h0000_0022, 32'h8000_0011};
  localparam logic [31:0] B_ID  = 32'hB0B0_0007;
  localparam logic [63:0] B_RST = {32'h0000_BBBB, 32'h0000_AAAA};
  localparam logic [31:0] FILL  = 32'hA5A5_A5A5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_a, cyc_b, stb, we;
  logic [7:0]  adr;
  logic [31:0] wdat;
  logic [63:0] stat_a;
  logic [31:0] stat_b;

  logic [31:0] a_dat, b_dat;
  logic        a_ack, a_err, b_ack, b_err;
  logic [95:0] a_ctrl;
  logic [63:0] b_ctrl;
  logic [2:0]  a_ctrl_wr;
  logic [1:0]  a_stat_rd, b_ctrl_wr;
  logic        b_stat_rd;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_rw, m_wo;
  logic [31:0] m_ctrl [3];

  always #4 clk = ~clk;

  wb_diag_regbank #(
    .ADDR_W(8), .ID_WORD(A_ID), .VER_WORD(A_VER), .DIAG_EN(1),
    .N_CTRL(3), .N_STAT(2), .CTRL_RST(A_RST),
    .CTRL_STB_EN(3'b101), .STAT_ACK_EN(2'b10)
  ) i_wb_diag_regbank (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc_a), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(a_dat), .wb_ack_o(a_ack),
    .wb_err_o(a_err), .ctrl_o(a_ctrl), .ctrl_wr_o(a_ctrl_wr),
    .stat_i(stat_a), .stat_rd_o(a_stat_rd)
  );

  wb_diag_regbank #(
    .ADDR_W(8), .ID_WORD(B_ID), .VER_WORD(32'h0000_0009), .DIAG_EN(0),
    .N_CTRL(2), .N_STAT(1), .CTRL_RST(B_RST),
    .CTRL_STB_EN(2'b10), .STAT_ACK_EN(1'b1)
  ) i_wb_diag_regbank_nodiag (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc_b), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(b_dat), .wb_ack_o(b_ack),
    .wb_err_o(b_err), .ctrl_o(b_ctrl), .ctrl_wr_o(b_ctrl_wr),
    .stat_i(stat_b), .stat_rd_o(b_stat_rd)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a <= 8'd1) return "R1 id/version";
    if (a == 8'd2) return "R3 scratch";
    if (a == 8'd3) return "R4 write-only";
    if (a == 8'd4) return "R5 loopback";
    if (a >= 8'd6 && a <= 8'd8) return "R8 control";
    if (a == 8'd9 || a == 8'd10) return "R10 status";
    return "R12 unmapped";
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    case (a)
      8'd0: return A_ID;
      8'd1: return A_VER;
      8'd2: return m_rw;
      8'd4: return m_wo;
      8'd6: return m_ctrl[0];
      8'd7: return m_ctrl[1];
      8'd8: return m_ctrl[2];
      8'd9: return stat_a[31:0];
      8'd10: return stat_a[63:32];
      default: return FILL;
    endcase
  endfunction

  // One complete transfer on instance A (diagnostics on), checked against the model.
  task automatic a_op(input bit w, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd, ev;
    logic [2:0]  cwr, ecwr;
    logic [1:0]  srd, esrd;
    bit ak, er, ak2, eerr;
    string tag;
    tag  = tag_of(a);
    eerr = !w && a == 8'd3;
    ev   = exp_word(a);
    ecwr = (w && a == 8'd6) ? 3'b001 : (w && a == 8'd8) ? 3'b100 : 3'b000;
    esrd = (!w && a == 8'd10) ? 2'b10 : 2'b00;
    cyc_a = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(posedge clk); @(negedge clk);
    rd = a_dat; ak = a_ack; er = a_err; cwr = a_ctrl_wr; srd = a_stat_rd;
    cyc_a = 1'b0; stb = 1'b0; we = 1'b0;
    if (w) begin
      if (a == 8'd2) m_rw = d;
      if (a == 8'd3) m_wo = d;
      if (a >= 8'd6 && a <= 8'd8) m_ctrl[a-8'd6] = d;
    end
    @(posedge clk); @(negedge clk);
    ak2 = a_ack | a_err;
    chk(ak == !eerr, {tag, " ack"}, 96'(ak), 96'(!eerr));
    chk(er == eerr, {tag, " err"}, 96'(er), 96'(eerr));
    if (!w && !eerr) chk(rd == ev, {tag, " data"}, 96'(rd), 96'(ev));
    chk(!ak2, "R2 single-cycle response", 96'(ak2), 96'(0));
    chk(cwr == ecwr, "R9 write strobe", 96'(cwr), 96'(ecwr));
    chk(srd == esrd, "R11 read pulse", 96'(srd), 96'(esrd));
    chk(a_ctrl == {m_ctrl[2], m_ctrl[1], m_ctrl[0]}, "R8 ctrl_o",
        a_ctrl, {m_ctrl[2], m_ctrl[1], m_ctrl[0]});
  endtask

  // One transfer on instance B (diagnostics off) with explicit expectations.
  task automatic b_op(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] ev, input logic [1:0] ecwr, input bit esrd);
    logic [31:0] rd;
    logic [1:0]  cwr;
    bit ak, er, srd;
    cyc_b = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(posedge clk); @(negedge clk);
    rd = b_dat; ak = b_ack; er = b_err; cwr = b_ctrl_wr; srd = b_stat_rd;
    cyc_b = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ak && !er, "R7 B response", {ak, er}, 96'b10);
    if (!w) chk(rd == ev, "R7 B data", 96'(rd), 96'(ev));
    chk(cwr == ecwr, "R7 R9 B strobe", 96'(cwr), 96'(ecwr));
    chk(srd == esrd, "R7 R11 B pulse", 96'(srd), 96'(esrd));
  endtask

  task automatic hang_op(input bit w);
    cyc_a = 1'b1; stb = 1'b1; we = w; adr = 8'd5; wdat = 32'h1111_2222;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!(a_ack | a_err), "R6 no response", {a_ack, a_err}, 96'b0);
    end
    cyc_a = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst_n = 1'b0; cyc_a = 1'b0; cyc_b = 1'b0; stb = 1'b0; we = 1'b0;
    adr = '0; wdat = '0; stat_a = 64'h0; stat_b = 32'h0;
    m_rw = '0; m_wo = '0;
    m_ctrl[0] = A_RST[31:0]; m_ctrl[1] = A_RST[63:32]; m_ctrl[2] = A_RST[95:64];
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!a_ack && !a_err && !b_ack && !b_err, "R13 response low in reset",
        {a_ack, a_err, b_ack, b_err}, 96'b0);
    chk(a_ctrl == A_RST, "R13 A ctrl defaults", a_ctrl, A_RST);
    chk(b_ctrl == B_RST, "R13 B ctrl defaults", 96'(b_ctrl), 96'(B_RST));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    a_op(0, 8'd0, 0);
    a_op(0, 8'd1, 0);
    a_op(1, 8'd0, 32'hFFFF_0000);
    a_op(0, 8'd0, 0);
    // R3
    a_op(0, 8'd2, 0);
    a_op(1, 8'd2, 32'h5A5A_1234);
    a_op(0, 8'd2, 0);
    // R4 / R5
    a_op(0, 8'd4, 0);
    a_op(1, 8'd3, 32'hDEAD_BEEF);
    a_op(0, 8'd3, 0);
    a_op(0, 8'd4, 0);
    a_op(1, 8'd4, 32'h0000_0001);
    a_op(0, 8'd4, 0);
    // R6
    hang_op(1'b0);
    hang_op(1'b1);
    a_op(0, 8'd2, 0);
    // R8 / R9
    a_op(0, 8'd6, 0);
    a_op(1, 8'd6, 32'h0F0F_0F0F);
    a_op(1, 8'd7, 32'h1234_5678);
    a_op(1, 8'd8, 32'hFFFF_FFFF);
    a_op(0, 8'd7, 0);
    // R10 / R11
    stat_a = {32'hCAFE_0010, 32'h0BAD_0009};
    a_op(0, 8'd9, 0);
    a_op(0, 8'd10, 0);
    a_op(1, 8'd10, 32'h7777_7777);
    stat_a = {32'h0000_1111, 32'h2222_0000};
    a_op(0, 8'd10, 0);
    // R12
    a_op(0, 8'd11, 0);
    a_op(0, 8'd255, 0);
    a_op(1, 8'd200, 32'h9999_9999);
    a_op(0, 8'd200, 0);

    // R7 instance without diagnostics
    stat_b = 32'h4444_5555;
    b_op(0, 8'd0, 0, B_ID, 2'b00, 1'b0);
    b_op(0, 8'd2, 0, 32'h0000_AAAA, 2'b00, 1'b0);
    b_op(0, 8'd3, 0, 32'h0000_BBBB, 2'b00, 1'b0);
    b_op(0, 8'd4, 0, 32'h4444_5555, 2'b00, 1'b1);
    b_op(0, 8'd5, 0, FILL, 2'b00, 1'b0);
    b_op(1, 8'd5, 32'h1, 0, 2'b00, 1'b0);
    b_op(1, 8'd2, 32'h0000_0C0C, 0, 2'b00, 1'b0);
    b_op(1, 8'd3, 32'h0000_0D0D, 0, 2'b10, 1'b0);
    chk(b_ctrl == {32'h0000_0D0D, 32'h0000_0C0C}, "R7 R8 B ctrl_o",
        96'(b_ctrl), 96'({32'h0000_0D0D, 32'h0000_0C0C}));

    // Random mix on instance A
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int pick;
      pick = int'($urandom % 8);
      case (pick)
        0: a = 8'd2;
        1: a = 8'd3;
        2: a = 8'd4;
        3: a = 8'(6 + $urandom % 3);
        4: a = 8'(9 + $urandom % 2);
        5: a = 8'(11 + $urandom % 245);
        6: a = 8'd0;
        default: a = 8'd1;
      endcase
      stat_a = {$urandom, $urandom};
      a_op(bit'($urandom % 2), a, $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule